// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. Between edges, all of its logic is combinational. The program counter selects a word from an internal instruction store. The fields of that word address a 32-entry register file. An ALU then adds, subtracts or ANDs the operands, and the result passes to the data store or back to the register file. Seven instruction kinds are handled: add, subtract, AND, load word, store word, branch-if-equal, and a no-op class that covers every unrecognised encoding.

Both stores are word arrays inside the core. While reset is held, a load port fills them one word per cycle. Once reset is released, execution starts at address 0. Two groups of commit outputs show what the core does in each cycle. One group gives the register write that the current instruction makes at the coming edge. The other gives the data-store write. The current program counter is also an output. The decoder sorts each word into one of five instruction classes: NOP, RTYPE, LOAD, STORE and BRANCH. An enumerated case over this class drives every select and enable line.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter and all 32 registers to 0. While reset is high, the core writes neither the register file nor the data store, and both commit enables read 0. A load port write while in reset places `load_data` at word `load_addr` of the instruction store (`load_dmem`=0) or of the data store (`load_dmem`=1).
- R2: For any instruction that is not a taken branch, the next program counter is the current value plus 4.
- R3: Opcode 0 (bits 31:26) is a register-to-register operation. Funct (bits 5:0) selects the operation: 0x20 adds, 0x22 subtracts (rs minus rt) and 0x24 ANDs. Register rs sits in bits 25:21, rt in 20:16 and rd in 15:11. The result is written to rd.
- R4: Opcode 0x23 loads a word. The address is rs plus bits 15:0 sign-extended to 32 bits, and the data word is addressed by address bits 7:2. The word read is written to rt, so negative offsets work.
- R5: Opcode 0x2B stores the value of rt at rs plus the sign-extended offset. It makes no register write.
- R6: Opcode 0x04 compares rs and rt by subtraction. When the difference is zero, the next program counter is PC+4 plus the sign-extended offset shifted left by two bits. Otherwise the next program counter is PC+4.
- R7: Register 0 always reads as 0, and a write aimed at it leaves it 0.
- R8: Any other opcode, and any opcode-0 word with another funct, is a no-op. It writes nothing and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load port write strobe, used only while in reset |
| load_dmem | input | 1 | Load target: 0 for the instruction store, 1 for the data store |
| load_addr | input | MEM_AW | Word index for a load port write |
| load_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | The current instruction writes a register at the next edge |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written to the destination register |
| dm_we_o | output | 1 | The current instruction writes the data store at the next edge |
| dm_addr_o | output | 32 | Byte address for the data-store access |
| dm_wdata_o | output | 32 | Value written to the data store |

## Verification
All commit outputs are combinational functions of the state that the most recent rising edge left behind. The effect of an instruction therefore shows on the ports in the same cycle that the program counter points at it. The next value of `pc_o` is due exactly one edge later. The bench samples just after each falling edge. It first compares the ports with a behavioural model of the state before the coming edge, and then advances that model by one instruction. In this way each register value, store value and branch target is checked one cycle after the edge that produced it. Reset is tested at start-up and again in the middle of a run, by storing a register that held a non-zero value before reset.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE  = 6'h00;
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;
    localparam logic [5:0] OPC_BRANCH = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NOP    = 3'd0,
        CLS_RTYPE  = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } iclass_e;

    typedef struct packed {
        iclass_e cls;
        alu_op_e op;
        logic    reg_we;
        logic    dst_rd;
        logic    use_imm;
        logic    wb_mem;
        logic    mem_we;
        logic    mem_re;
        logic    branch;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    iclass_e cls;
    alu_op_e rop;

    // Classify the instruction word
    always_comb begin
        rop = ALU_ADD;
        cls = CLS_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                case (funct)
                    FN_ADD:  begin cls = CLS_RTYPE; rop = ALU_ADD; end
                    FN_SUB:  begin cls = CLS_RTYPE; rop = ALU_SUB; end
                    FN_AND:  begin cls = CLS_RTYPE; rop = ALU_AND; end
                    default: cls = CLS_NOP;
                endcase
            end
            OPC_LOAD:   cls = CLS_LOAD;
            OPC_STORE:  cls = CLS_STORE;
            OPC_BRANCH: cls = CLS_BRANCH;
            default:    cls = CLS_NOP;
        endcase
    end

    // Drive the control lines from the class
    always_comb begin
        ctl     = '0;
        ctl.cls = cls;
        unique case (cls)
            CLS_RTYPE: begin
                ctl.op     = rop;
                ctl.reg_we = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            CLS_LOAD: begin
                ctl.op      = ALU_ADD;
                ctl.reg_we  = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.mem_re  = 1'b1;
            end
            CLS_STORE: begin
                ctl.op      = ALU_ADD;
                ctl.use_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            CLS_BRANCH: begin
                ctl.op     = ALU_SUB;
                ctl.branch = 1'b1;
            end
            default: ctl.op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R7
    r0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr == '0)) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int NREG   = 32,
    localparam int MEM_WORDS = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_dmem,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    output logic [31:0]       pc_o,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [31:0]       rf_wdata_o,
    output logic              dm_we_o,
    output logic [31:0]       dm_addr_o,
    output logic [31:0]       dm_wdata_o
);

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0] instr, imm_ext, br_off;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic [REG_AW-1:0] waddr;
    logic            alu_zero, taken;
    ctrl_t           ctl;

    // Program counter state
    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    // Instruction store: filled through the load port during reset
    always_ff @(posedge clk) begin
        if (rst && load_en && !load_dmem) imem[load_addr] <= load_data;
    end

    assign instr = imem[pc[MEM_AW+1:2]];

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    sc_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (rf_we_o),
        .waddr (waddr),
        .wdata (wb_data)
    );

    // Immediate path
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign br_off  = {imm_ext[XLEN-3:0], 2'b00};

    // Operand multiplexer
    assign alu_b = ctl.use_imm ? imm_ext : rt_val;

    sc_alu #(.DW(XLEN)) u_alu (
        .op   (ctl.op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store
    always_ff @(posedge clk) begin
        if (rst) begin
            if (load_en && load_dmem) dmem[load_addr] <= load_data;
        end else if (ctl.mem_we) begin
            dmem[alu_y[MEM_AW+1:2]] <= rt_val;
        end
    end

    assign dm_rdata = ctl.mem_re ? dmem[alu_y[MEM_AW+1:2]] : '0;

    // Write-back and destination multiplexers
    assign wb_data = ctl.wb_mem ? dm_rdata : alu_y;
    assign waddr   = ctl.dst_rd ? instr[15:11] : instr[20:16];

    // Next-address adders
    assign pc_plus4  = pc + 32'd4;
    assign br_target = pc_plus4 + br_off;
    assign taken     = ctl.branch & alu_zero;
    assign pc_next   = taken ? br_target : pc_plus4;

    assign pc_o       = pc;
    assign rf_we_o    = ctl.reg_we & ~rst;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctl.mem_we & ~rst;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == '0));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o));
    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.branch && (rs_val == rt_val)) |=> (pc == $past(pc) + 32'd4));
    // R6
    branch_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && (rs_val == rt_val)) |=> (pc == $past(br_target)));
    // R6
    alu_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl.op == ALU_SUB) && (rs_val == alu_b)) |-> alu_zero);
    // R5
    store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);
    // R8
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.cls == CLS_NOP) |-> (!rf_we_o && !dm_we_o));

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    localparam int AW = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic          load_dmem = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic [31:0]   pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]    rf_waddr_o;
    logic          rf_we_o, dm_we_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #2.5 clk = ~clk;

    sc_core #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;
    endtask

    task automatic load_word(bit to_dmem, int idx, logic [31:0] v);
        @(negedge clk);
        load_en = 1'b1; load_dmem = to_dmem; load_addr = AW'(idx); load_data = v;
        if (to_dmem) m_dmem[idx] = v;
        else         m_imem[idx] = v;
    endtask

    // Compare the ports with the model, then advance the model one instruction
    task automatic compare_and_step();
        logic [31:0] ins, sx, a, b, res, addr;
        logic [5:0]  op, fn;
        int rs, rt, rd;
        bit e_rf, e_dm, tk;
        int e_dst;
        logic [31:0] e_val;
        string tg;
        ins = m_imem[m_pc[AW+1:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        sx = {{16{ins[15]}}, ins[15:0]};
        a = m_reg[rs]; b = m_reg[rt];
        e_rf = 0; e_dm = 0; tk = 0; e_dst = 0; e_val = '0; addr = '0; res = '0;
        tg = "R8";
        if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24)) begin
            res = (fn == 6'h20) ? a + b : (fn == 6'h22) ? a - b : (a & b);
            e_rf = 1; e_dst = rd; e_val = res;
            tg = (rd == 0) ? "R7" : "R3";
        end else if (op == 6'h23) begin
            addr = a + sx;
            e_rf = 1; e_dst = rt; e_val = m_dmem[addr[AW+1:2]];
            tg = "R4";
        end else if (op == 6'h2B) begin
            addr = a + sx;
            e_dm = 1;
            tg = (m_pc == 0) ? "R1" : (rt == 0) ? "R7" : "R5";
        end else if (op == 6'h04) begin
            tk = (a == b);
            tg = "R6";
        end
        check(tk ? "R6" : "R2", "pc", pc_o, m_pc);
        check(tg, "rf_we", 32'(rf_we_o), 32'(e_rf));
        check(tg, "dm_we", 32'(dm_we_o), 32'(e_dm));
        if (e_rf) begin
            check(tg, "rf_waddr", 32'(rf_waddr_o), 32'(e_dst));
            check(tg, "rf_wdata", rf_wdata_o, e_val);
        end
        if (e_dm) begin
            check(tg, "dm_addr", dm_addr_o, addr);
            check(tg, "dm_wdata", dm_wdata_o, b);
        end
        if (e_rf && e_dst != 0) m_reg[e_dst] = e_val;
        if (e_dm) m_dmem[addr[AW+1:2]] = b;
        m_pc = tk ? (m_pc + 32'd4 + {sx[29:0], 2'b00}) : (m_pc + 32'd4);
    endtask

    task automatic check_in_reset();
        check("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
        check("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) rst = 1'b0;
            #1;
            compare_and_step();
        end
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            m_imem[i] = '0;
            m_dmem[i] = '0;
        end
        model_reset();
        repeat (2) @(negedge clk);
        #1 check_in_reset();
        for (int i = 0; i < WORDS; i++) load_word(1'b0, i, 32'h0);
        load_word(1'b0, 0,  enc_i(6'h2B, 0, 3, 0));      // store r3 (reset value)
        load_word(1'b0, 1,  enc_i(6'h23, 0, 1, 16));     // r1 = 5
        load_word(1'b0, 2,  enc_i(6'h23, 0, 2, 20));     // r2 = -16
        load_word(1'b0, 3,  enc_r(6'h20, 1, 2, 3));      // add
        load_word(1'b0, 4,  enc_r(6'h22, 1, 2, 4));      // sub
        load_word(1'b0, 5,  enc_r(6'h24, 1, 2, 6));      // and
        load_word(1'b0, 6,  enc_r(6'h20, 1, 1, 0));      // write to r0
        load_word(1'b0, 7,  enc_i(6'h2B, 1, 0, 3));      // store r0
        load_word(1'b0, 8,  enc_i(6'h23, 4, 7, -1));     // negative offset load
        load_word(1'b0, 9,  enc_i(6'h04, 1, 2, 5));      // branch not taken
        load_word(1'b0, 10, enc_i(6'h04, 1, 1, 2));      // branch taken forward
        load_word(1'b0, 11, enc_r(6'h20, 1, 1, 9));      // skipped
        load_word(1'b0, 12, enc_r(6'h20, 1, 1, 9));      // skipped
        load_word(1'b0, 13, 32'hFC00_0000);              // unknown opcode
        load_word(1'b0, 14, enc_r(6'h25, 1, 2, 11));     // unknown funct
        load_word(1'b0, 15, enc_i(6'h2B, 0, 3, 24));     // store r3
        load_word(1'b0, 16, enc_i(6'h23, 0, 10, 24));    // reload it
        load_word(1'b0, 17, enc_i(6'h04, 0, 0, -17));    // branch back
        load_word(1'b1, 4, 32'h0000_0005);
        load_word(1'b1, 5, 32'hFFFF_FFF0);
        @(negedge clk);
        load_en = 1'b0;
        #1 check_in_reset();
        check("R1", "pc after reset", pc_o, 32'd0);
        run(60);
        // Second reset with live register contents
        @(negedge clk);
        rst = 1'b1;
        #1 check_in_reset();
        @(negedge clk);
        #1 check_in_reset();
        check("R1", "pc in reset", pc_o, 32'd0);
        model_reset();
        run(25);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule